// File: doc/BRIEF.md
# GPIO Edge Interrupt and Wake Controller

This block watches the general purpose input pins of three ports (port 0 with 8 pins, port 1 with 8 pins, port 2 with 5 pins; 21 pins in total) and turns selected edges on them into one interrupt request per port and a single combined wake request. Pin inputs are asynchronous. They are synchronized and compared against their previous sample. A qualifying edge sets a sticky per-pin flag that software later clears by writing ones.

Each port selects whether rising or falling edges count, and has a common enable. Below that common enable, port 1 has one enable per pin, port 0 has one enable per group of four pins, and port 2 relies on its common enable alone. A pin driven as an output neither raises nor contributes a flag. The wake request is a combinational OR of the port requests. It needs only the always-on detection clock, not the processor clock. Register decoding is left to the surrounding logic, which presents per-port clear strobes and a shared data byte.

Top module: `gpio_edge_wake`

## Requirements
- R1: While reset is asserted and right after it, `flags` is all zero and `portIrq` and `wakeReq` are low.
- R2: With `edgeFall[p]` = 0, a low-to-high change on an input pin of port p sets that pin's flag. The flag is visible after the third rising clock edge that follows the change, and not after the second.
- R3: With `edgeFall[p]` = 1, only high-to-low changes set flags of port p. A change in the opposite direction sets nothing.
- R4: A flag stays set until a cycle with `clrWr[p]` high and `clrData` bit i high, where i is the pin's bit within port p. Zero data bits and strobes for other ports leave it unchanged.
- R5: When a flag is set and cleared in the same cycle, the set wins and the flag ends up 1.
- R6: `portIrq[0]` is high when `portEn[0]` is high and a flag in bits 3..0 is set with `p0NibEn[0]`, or a flag in bits 7..4 is set with `p0NibEn[1]`.
- R7: `portIrq[1]` is high when `portEn[1]` is high and some flag of port 1 bit i is set with `p1BitEn[i]` high.
- R8: `portIrq[2]` is high when `portEn[2]` is high and any port 2 flag is set.
- R9: A pin with `pinDir` bit = 1 (output) never sets its flag, and its flag is excluded from the port request.
- R10: `wakeReq` is high exactly when any `portIrq` bit is high.
- R11: Pin levels present when reset is released do not set flags. Detection starts once the synchronizer holds real samples.
- R12: Enables gate only the requests: flags still set on qualifying edges when every enable is low.

Pin and flag bit order on `pinIn`, `pinDir` and `flags`: port 0 at bits 7..0, port 1 at bits 15..8, port 2 at bits 20..16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on detection clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 21 | Asynchronous pin levels |
| pinDir | input | 21 | 1 = pin is an output |
| edgeFall | input | 3 | Per port: 1 = falling edges, 0 = rising edges |
| portEn | input | 3 | Common enable per port |
| p0NibEn | input | 2 | Port 0 group enables (bit 0 for pins 3..0, bit 1 for pins 7..4) |
| p1BitEn | input | 8 | Port 1 per-pin enables |
| clrWr | input | 3 | Per-port clear strobe |
| clrData | input | 8 | Write-one-to-clear data for the strobed port |
| flags | output | 21 | Sticky edge flags |
| portIrq | output | 3 | Interrupt request per port |
| wakeReq | output | 1 | Combined wake request |

## Verification
The vector table moves pins from one level pattern to another under different edge selections, enables and directions. Same-direction changes on all ports under rising and falling selection separate correct edge polarity from plain level sensing. Mixed per-port polarity exposes swapped select bits. Group and per-pin enable patterns with deliberately mismatched flagged pins separate port 0 group gating from port 1 bit gating. Output directions show masking. Directed sequences pin down the three-edge latency, set-over-clear collision, partial and wrong-port clears, and the quiet start after reset with pins held high.

// File: rtl/gpio_edge_wake_pkg.sv
package gpio_edge_wake_pkg;
  localparam int NUM_PORTS = 3;
  localparam int P0_W = 8;
  localparam int P1_W = 8;
  localparam int P2_W = 5;
  localparam int PIN_W = P0_W + P1_W + P2_W;
  localparam int DATA_W = 8;
  localparam int NIB_W = 4;
  localparam int P0_GROUPS = P0_W / NIB_W;

  function automatic int portLo(input int p);
    case (p)
      0: return 0;
      1: return P0_W;
      default: return P0_W + P1_W;
    endcase
  endfunction

  function automatic int portWidth(input int p);
    case (p)
      0: return P0_W;
      1: return P1_W;
      default: return P2_W;
    endcase
  endfunction

  function automatic logic [PIN_W-1:0] portField(input int p);
    logic [PIN_W-1:0] m;
    m = '0;
    for (int i = 0; i < PIN_W; i++)
      if (i >= portLo(p) && i < portLo(p) + portWidth(p)) m[i] = 1'b1;
    return m;
  endfunction

  typedef struct packed {
    logic [PIN_W-1:0] clrVec;
    logic [PIN_W-1:0] fallSel;
    logic [PIN_W-1:0] irqMask;
    logic [PIN_W-1:0] inputMask;
    logic             detectEn;
  } ctrlStrobe_t;
endpackage

// File: rtl/gpio_edge_wake_ctrl.sv
module gpio_edge_wake_ctrl
  import gpio_edge_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] clrWr,
  input  logic [DATA_W-1:0]    clrData,
  input  logic [NUM_PORTS-1:0] edgeFall,
  input  logic [NUM_PORTS-1:0] portEn,
  input  logic [P0_GROUPS-1:0] p0NibEn,
  input  logic [P1_W-1:0]      p1BitEn,
  input  logic [PIN_W-1:0]     pinDir,
  output ctrlStrobe_t          ctrl
);
  localparam int PRIME = SYNC_STAGES + 1;
  localparam int CNT_W = $clog2(PRIME + 1);

  logic [PIN_W-1:0] clrVec;
  logic [PIN_W-1:0] fallSel;
  logic [PIN_W-1:0] irqMask;
  logic [CNT_W-1:0] primeCnt;
  logic             primed;

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam int LO = portLo(p);
      localparam int W  = portWidth(p);
      assign clrVec[LO +: W]  = clrWr[p] ? clrData[W-1:0] : '0;
      assign fallSel[LO +: W] = {W{edgeFall[p]}};
      if (p == 0) begin : g_nibble
        for (genvar g = 0; g < P0_GROUPS; g++) begin : g_grp
          assign irqMask[LO + g*NIB_W +: NIB_W] = {NIB_W{p0NibEn[g] & portEn[p]}};
        end
      end else if (p == 1) begin : g_bitwise
        assign irqMask[LO +: W] = p1BitEn & {W{portEn[p]}};
      end else begin : g_common
        assign irqMask[LO +: W] = {W{portEn[p]}};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primeCnt <= '0;
    else if (!primed) primeCnt <= primeCnt + 1'b1;
  end

  assign primed = (primeCnt == CNT_W'(PRIME));

  always_comb begin
    ctrl.clrVec    = clrVec;
    ctrl.fallSel   = fallSel;
    ctrl.irqMask   = irqMask;
    ctrl.inputMask = ~pinDir;
    ctrl.detectEn  = primed;
  end

  // R11: once detection is armed it stays armed until the next reset
  assert_prime_holds_R11: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.detectEn |=> ctrl.detectEn);
endmodule

// File: rtl/gpio_edge_wake_dp.sv
module gpio_edge_wake_dp
  import gpio_edge_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_W-1:0]     pinIn,
  input  ctrlStrobe_t          ctrl,
  output logic [PIN_W-1:0]     flags,
  output logic [NUM_PORTS-1:0] portIrq
);
  logic [PIN_W-1:0] syncChain [SYNC_STAGES];
  logic [PIN_W-1:0] prevSample;
  logic [PIN_W-1:0] curSample;
  logic [PIN_W-1:0] riseHit;
  logic [PIN_W-1:0] fallHit;
  logic [PIN_W-1:0] setVec;
  logic [PIN_W-1:0] flagNext;
  logic [PIN_W-1:0] liveFlags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncChain[s] <= '0;
      prevSample <= '0;
    end else begin
      syncChain[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncChain[s] <= syncChain[s-1];
      prevSample <= syncChain[SYNC_STAGES-1];
    end
  end

  assign curSample = syncChain[SYNC_STAGES-1];
  assign riseHit   = curSample & ~prevSample;
  assign fallHit   = ~curSample & prevSample;
  assign setVec    = ((ctrl.fallSel & fallHit) | (~ctrl.fallSel & riseHit))
                   & ctrl.inputMask & {PIN_W{ctrl.detectEn}};
  assign flagNext  = (flags & ~ctrl.clrVec) | setVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= flagNext;
  end

  assign liveFlags = flags & ctrl.irqMask & ctrl.inputMask;

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_irq
      assign portIrq[p] = |(liveFlags & portField(p));

      // R6 R7 R8: a port request needs a set flag of that port
      assert_irq_has_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
        portIrq[p] |-> |(flags & portField(p)));
    end
  endgenerate

  // R4: a flag only drops in a cycle after its clear bit was presented
  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (($past(flags) & ~$past(ctrl.clrVec) & ~flags) == '0));

  // R5: a detected edge coinciding with a clear leaves the flag set
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (($past(setVec & ctrl.clrVec) & ~flags) == '0));

  // R9: output pins never gain a flag
  assert_output_no_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((flags & ~$past(flags) & ~$past(ctrl.inputMask)) == '0));
endmodule

// File: rtl/gpio_edge_wake.sv
module gpio_edge_wake
  import gpio_edge_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [20:0] pinIn,
  input  logic [20:0] pinDir,
  input  logic [2:0]  edgeFall,
  input  logic [2:0]  portEn,
  input  logic [1:0]  p0NibEn,
  input  logic [7:0]  p1BitEn,
  input  logic [2:0]  clrWr,
  input  logic [7:0]  clrData,
  output logic [20:0] flags,
  output logic [2:0]  portIrq,
  output logic        wakeReq
);
  ctrlStrobe_t ctrl;

  gpio_edge_wake_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clrWr    (clrWr),
    .clrData  (clrData),
    .edgeFall (edgeFall),
    .portEn   (portEn),
    .p0NibEn  (p0NibEn),
    .p1BitEn  (p1BitEn),
    .pinDir   (pinDir),
    .ctrl     (ctrl)
  );

  gpio_edge_wake_dp #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .ctrl    (ctrl),
    .flags   (flags),
    .portIrq (portIrq)
  );

  assign wakeReq = |portIrq;

  // R1: reset keeps every request quiet
  always @(negedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (flags == '0 && portIrq == '0 && !wakeReq);
    end
  end
endmodule

// File: tb/test_gpio_edge_wake.sv
module test_gpio_edge_wake;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [20:0] pinIn = '1;
  logic [20:0] pinDir = '0;
  logic [2:0]  edgeFall = '0;
  logic [2:0]  portEn = '1;
  logic [1:0]  p0NibEn = '1;
  logic [7:0]  p1BitEn = '1;
  logic [2:0]  clrWr = '0;
  logic [7:0]  clrData = '0;
  logic [20:0] flags;
  logic [2:0]  portIrq;
  logic        wakeReq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_edge_wake i_gpio_edge_wake (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinDir(pinDir),
    .edgeFall(edgeFall), .portEn(portEn), .p0NibEn(p0NibEn),
    .p1BitEn(p1BitEn), .clrWr(clrWr), .clrData(clrData),
    .flags(flags), .portIrq(portIrq), .wakeReq(wakeReq)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic [2:0]  en;
    logic [1:0]  nib;
    logic [7:0]  bits;
    logic [20:0] dir;
    logic [20:0] pa;
    logic [20:0] pb;
    logic [20:0] expF;
    logic [2:0]  expI;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t TBL [NVEC] = '{
    '{3'b000, 3'b111, 2'b11, 8'hFF, 21'h0,      21'h0,      21'h000001, 21'h000001, 3'b001},
    '{3'b000, 3'b111, 2'b11, 8'hFF, 21'h0,      21'h0,      21'h1FFFFF, 21'h1FFFFF, 3'b111},
    '{3'b111, 3'b111, 2'b11, 8'hFF, 21'h0,      21'h1FFFFF, 21'h0,      21'h1FFFFF, 3'b111},
    '{3'b000, 3'b111, 2'b11, 8'hFF, 21'h0,      21'h1FFFFF, 21'h0,      21'h000000, 3'b000},
    '{3'b010, 3'b111, 2'b11, 8'hFF, 21'h0,      21'h0,      21'h1FFFFF, 21'h1F00FF, 3'b101},
    '{3'b000, 3'b111, 2'b10, 8'h00, 21'h0,      21'h0,      21'h00080F, 21'h00080F, 3'b000},
    '{3'b000, 3'b111, 2'b10, 8'h08, 21'h0,      21'h0,      21'h0008F0, 21'h0008F0, 3'b011},
    '{3'b000, 3'b010, 2'b11, 8'hFF, 21'h0,      21'h0,      21'h1FFFFF, 21'h1FFFFF, 3'b010},
    '{3'b000, 3'b111, 2'b11, 8'hFF, 21'h1F00F0, 21'h0,      21'h1FFFFF, 21'h00FF0F, 3'b011}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic clearAll();
    clrWr = 3'b111;
    clrData = 8'hFF;
    @(negedge clk);
    clrWr = '0;
    clrData = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state with pins held high
    tick(3);
    check("R1 flags in reset", 32'(flags), 32'h0);
    check("R1 portIrq in reset", 32'(portIrq), 32'h0);
    check("R1 wakeReq in reset", 32'(wakeReq), 32'h0);
    rstN = 1'b1;
    // R11: levels present at reset release are not edges
    tick(6);
    check("R11 no flags after release", 32'(flags), 32'h0);
    check("R11 R1 no wake after release", 32'(wakeReq), 32'h0);

    // Table: R2 R3 R6 R7 R8 R9 R10 R12
    for (int i = 0; i < NVEC; i++) begin
      edgeFall = TBL[i].sel;
      portEn   = TBL[i].en;
      p0NibEn  = TBL[i].nib;
      p1BitEn  = TBL[i].bits;
      pinDir   = TBL[i].dir;
      pinIn    = TBL[i].pa;
      tick(5);
      clearAll();
      pinIn = TBL[i].pb;
      tick(5);
      check($sformatf("R2 R3 R9 R12 table %0d flags", i), 32'(flags), 32'(TBL[i].expF));
      check($sformatf("R6 R7 R8 R9 table %0d portIrq", i), 32'(portIrq), 32'(TBL[i].expI));
      check($sformatf("R10 table %0d wakeReq", i), 32'(wakeReq), 32'(|TBL[i].expI));
    end

    // R2: latency of a rising edge on port 1 bit 0
    edgeFall = '0; portEn = '1; p0NibEn = '1; p1BitEn = '1; pinDir = '0;
    pinIn = '0;
    tick(5);
    clearAll();
    pinIn[8] = 1'b1;
    tick(2);
    check("R2 flag not yet after two edges", 32'(flags[8]), 32'h0);
    tick(1);
    check("R2 flag after third edge", 32'(flags[8]), 32'h1);
    check("R7 R10 port1 request", 32'({portIrq, wakeReq}), 32'b0101);

    // R4: zero data and wrong port do not clear
    clrWr = 3'b010; clrData = 8'h00;
    tick(1);
    clrWr = 3'b101; clrData = 8'hFF;
    tick(1);
    clrWr = '0; clrData = '0;
    check("R4 flag survives non-matching clears", 32'(flags), 32'h000100);
    clrWr = 3'b010; clrData = 8'h01;
    tick(1);
    clrWr = '0; clrData = '0;
    check("R4 flag cleared by write one", 32'(flags), 32'h0);
    check("R4 R10 wake drops after clear", 32'(wakeReq), 32'h0);

    // R5: edge landing on the same cycle as a clear
    pinIn[9] = 1'b1;
    tick(2);
    clrWr = 3'b010; clrData = 8'h02;
    tick(1);
    clrWr = '0; clrData = '0;
    check("R5 set wins over clear", 32'(flags[9]), 32'h1);
    clrWr = 3'b010; clrData = 8'h02;
    tick(1);
    clrWr = '0; clrData = '0;
    check("R5 later clear succeeds", 32'(flags[9]), 32'h0);

    // R12: all enables off, flags still record edges
    portEn = '0; p0NibEn = '0; p1BitEn = '0;
    pinIn[16] = 1'b1;
    tick(4);
    check("R12 flag set with enables off", 32'(flags[16]), 32'h1);
    check("R8 R12 no request with enables off", 32'({portIrq, wakeReq}), 32'h0);
    portEn = 3'b100;
    tick(1);
    check("R8 port2 common enable alone", 32'({portIrq, wakeReq}), 32'b1001);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule